// File: doc/BRIEF.md
# Dual-Bank Masked Interrupt Aggregator

This block collects interrupt events for a six-channel descriptor-driven transfer engine and merges them into one interrupt line. Events fall into two banks. The normal bank holds per-channel completion flags, per-channel payload-fetch error flags and a frame-sync flag. The error bank holds per-channel flags for a failed descriptor fetch, a bad descriptor preamble, a checksum mismatch and the reuse of a descriptor that is already marked complete. Each event input is a single-cycle pulse that sets a sticky status bit at a fixed position.

Software reaches the block through a 32-bit word register port. The port has a 3-bit word address, a write strobe, write data and combinational read data. Each bank offers four registers: a status register that software clears by writing ones, a read-only mask, an unmask port and a mask-set port. Software changes the mask only through the unmask and mask-set ports. Both of those ports read as zero. The interrupt output is registered. It is high when any status bit in either bank is set while its mask bit is clear.

Register word addresses: 0 normal status, 1 normal mask, 2 normal unmask, 3 normal mask-set, 4 error status, 5 error mask, 6 error unmask, 7 error mask-set.

Top module: `irq_agg`

## Requirements
- R1: After reset every status bit is zero, the normal mask reads 0x07FFFFFF, the error mask reads 0xFFFFFFFF and `irq` is low.
- R2: A write to a status address (0 or 4) clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R3: A write to an unmask address (2 or 6) clears each mask bit of that bank whose write-data bit is 1. Reads of addresses 2 and 6 return zero.
- R4: A write to a mask-set address (3 or 7) sets each mask bit of that bank whose write-data bit is 1. Reads of addresses 3 and 7 return zero.
- R5: A write to a mask address (1 or 5) has no effect, and the mask keeps its value.
- R6: When an event sets a status bit in the same cycle that software clears it, the bit ends up set.
- R7: `irq` is a register. After each clock edge it holds the result of OR-ing (normal status AND NOT normal mask) with (error status AND NOT error mask), both taken as they were before that edge.
- R8: In the normal status register, `ch_done[n]` sets bit n, `ch_data_err[n]` sets bit 12+n, and `vsync` sets bit 27.
- R9: In the error status register, `ch_fetch_err[n]` sets bit 1+n, `ch_preamble_err[n]` sets bit 7+n, `ch_crc_err[n]` sets bit 13+n, and `ch_redone_err[n]` sets bit 25+n.
- R10: Status bits that no event maps to always read zero. With every event active, normal status is 0x0803F03F and error status is 0x7E07FFFE.
- R11: A status bit stays set after its event pulse ends. Only a clearing write removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register word address |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ch_done | input | NUM_CH | Per-channel completion pulses |
| ch_data_err | input | NUM_CH | Per-channel payload-fetch error pulses |
| vsync | input | 1 | Frame-sync pulse |
| ch_fetch_err | input | NUM_CH | Per-channel descriptor-fetch failure pulses |
| ch_preamble_err | input | NUM_CH | Per-channel bad-preamble pulses |
| ch_crc_err | input | NUM_CH | Per-channel checksum mismatch pulses |
| ch_redone_err | input | NUM_CH | Per-channel already-complete descriptor pulses |
| irq | output | 1 | Registered combined interrupt |

## Verification
The assertions assume a write strobe targets one address per cycle, so an unmask and a mask-set never reach the same bank together. They also assume `we` and every event input are low while reset is held, so the first `$past` sample after reset sees an idle bank. The stimulus changes inputs only on falling edges. It issues one write at a time and keeps all inputs at zero during reset. Event pulses sometimes coincide with clearing writes to the same bits, which exercises the set-over-clear rule within these limits.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int WORD_W = 32;
    localparam int REG_AW = 3;
    localparam int MAX_CH = 6;

    // normal bank bit positions (decoded by software)
    localparam int N_DONE_LSB  = 0;
    localparam int N_DERR_LSB  = 12;
    localparam int N_VSYNC_BIT = 27;

    // error bank bit positions (decoded by software)
    localparam int E_FETCH_LSB  = 1;
    localparam int E_PREAM_LSB  = 7;
    localparam int E_CRC_LSB    = 13;
    localparam int E_REDONE_LSB = 25;

    localparam logic [WORD_W-1:0] N_MASK_RST = 32'h07FF_FFFF;
    localparam logic [WORD_W-1:0] E_MASK_RST = 32'hFFFF_FFFF;

    typedef enum logic [REG_AW-1:0] {
        SEL_N_STAT    = 3'd0,
        SEL_N_MASK    = 3'd1,
        SEL_N_UNMASK  = 3'd2,
        SEL_N_MASKSET = 3'd3,
        SEL_E_STAT    = 3'd4,
        SEL_E_MASK    = 3'd5,
        SEL_E_UNMASK  = 3'd6,
        SEL_E_MASKSET = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] stat;
        logic [WORD_W-1:0] mask;
    } bank_st_t;

    typedef struct packed {
        logic irq;
    } out_st_t;
endpackage

// File: rtl/irqagg_evmap.sv
module irqagg_evmap
    import irqagg_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic [NUM_CH-1:0] ch_done,
    input  logic [NUM_CH-1:0] ch_data_err,
    input  logic              vsync,
    input  logic [NUM_CH-1:0] ch_fetch_err,
    input  logic [NUM_CH-1:0] ch_preamble_err,
    input  logic [NUM_CH-1:0] ch_crc_err,
    input  logic [NUM_CH-1:0] ch_redone_err,
    output logic [WORD_W-1:0] n_set,
    output logic [WORD_W-1:0] e_set
);
    logic [NUM_CH-1:0][WORD_W-1:0] n_part;
    logic [NUM_CH-1:0][WORD_W-1:0] e_part;

    // one placement per channel; OR-reduced below
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            n_part[c] = '0;
            e_part[c] = '0;
            n_part[c][N_DONE_LSB + c]   = ch_done[c];
            n_part[c][N_DERR_LSB + c]   = ch_data_err[c];
            e_part[c][E_FETCH_LSB + c]  = ch_fetch_err[c];
            e_part[c][E_PREAM_LSB + c]  = ch_preamble_err[c];
            e_part[c][E_CRC_LSB + c]    = ch_crc_err[c];
            e_part[c][E_REDONE_LSB + c] = ch_redone_err[c];
        end
    end

    always_comb begin
        n_set = '0;
        e_set = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            n_set = n_set | n_part[c];
            e_set = e_set | e_part[c];
        end
        n_set[N_VSYNC_BIT] = n_set[N_VSYNC_BIT] | vsync;
    end
endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank
    import irqagg_pkg::*;
#(
    parameter int                W        = WORD_W,
    parameter logic [WORD_W-1:0] MASK_RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] unmask_i,
    input  logic [W-1:0] maskset_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] mask_o
);
    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // an event beats a simultaneous clear
        st_d.stat = (st_q.stat & ~clr_i) | set_i;
        st_d.mask = (st_q.mask & ~unmask_i) | maskset_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat <= '0;
            st_q.mask <= MASK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;
endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irqagg_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] addr,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic [NUM_CH-1:0] ch_data_err,
    input  logic              vsync,
    input  logic [NUM_CH-1:0] ch_fetch_err,
    input  logic [NUM_CH-1:0] ch_preamble_err,
    input  logic [NUM_CH-1:0] ch_crc_err,
    input  logic [NUM_CH-1:0] ch_redone_err,
    output logic              irq
);
    reg_sel_e sel;
    logic [WORD_W-1:0] n_set, e_set;
    logic [WORD_W-1:0] n_clr, e_clr, n_en, e_en, n_dis, e_dis;
    logic [WORD_W-1:0] n_stat, n_mask, e_stat, e_mask;
    out_st_t o_d, o_q;

    assign sel = reg_sel_e'(addr);

    irqagg_evmap #(.NUM_CH(NUM_CH)) u_map (
        .ch_done         (ch_done),
        .ch_data_err     (ch_data_err),
        .vsync           (vsync),
        .ch_fetch_err    (ch_fetch_err),
        .ch_preamble_err (ch_preamble_err),
        .ch_crc_err      (ch_crc_err),
        .ch_redone_err   (ch_redone_err),
        .n_set           (n_set),
        .e_set           (e_set)
    );

    // write decode: each strobe vector is the write data or zero
    always_comb begin
        n_clr = '0; n_en = '0; n_dis = '0;
        e_clr = '0; e_en = '0; e_dis = '0;
        if (we) begin
            unique case (sel)
                SEL_N_STAT:    n_clr = wdata;
                SEL_N_UNMASK:  n_en  = wdata;
                SEL_N_MASKSET: n_dis = wdata;
                SEL_E_STAT:    e_clr = wdata;
                SEL_E_UNMASK:  e_en  = wdata;
                SEL_E_MASKSET: e_dis = wdata;
                default: ;  // mask addresses are read-only
            endcase
        end
    end

    irqagg_bank #(.W(WORD_W), .MASK_RST(N_MASK_RST)) u_nbank (
        .clk(clk), .rst_n(rst_n),
        .set_i(n_set), .clr_i(n_clr), .unmask_i(n_en), .maskset_i(n_dis),
        .stat_o(n_stat), .mask_o(n_mask)
    );

    irqagg_bank #(.W(WORD_W), .MASK_RST(E_MASK_RST)) u_ebank (
        .clk(clk), .rst_n(rst_n),
        .set_i(e_set), .clr_i(e_clr), .unmask_i(e_en), .maskset_i(e_dis),
        .stat_o(e_stat), .mask_o(e_mask)
    );

    always_comb begin
        o_d = o_q;
        o_d.irq = (|(n_stat & ~n_mask)) | (|(e_stat & ~e_mask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign irq = o_q.irq;

    always_comb begin
        unique case (sel)
            SEL_N_STAT: rdata = n_stat;
            SEL_N_MASK: rdata = n_mask;
            SEL_E_STAT: rdata = e_stat;
            SEL_E_MASK: rdata = e_mask;
            default:    rdata = '0;  // unmask / mask-set ports read zero
        endcase
    end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irqagg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic [WORD_W-1:0] n_stat,
    input logic [WORD_W-1:0] n_mask,
    input logic [WORD_W-1:0] e_stat,
    input logic [WORD_W-1:0] e_mask,
    input logic [WORD_W-1:0] n_set,
    input logic [WORD_W-1:0] e_set,
    input logic [WORD_W-1:0] n_clr,
    input logic [WORD_W-1:0] e_clr,
    input logic [WORD_W-1:0] n_en,
    input logic [WORD_W-1:0] e_en,
    input logic [WORD_W-1:0] n_dis,
    input logic [WORD_W-1:0] e_dis
);
    p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ($past(|(n_stat & ~n_mask)) || $past(|(e_stat & ~e_mask))))
        else $error("irq does not track unmasked status");

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(n_set) & ~n_stat) == '0) && (($past(e_set) & ~e_stat) == '0))
        else $error("event did not set status");

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(n_stat) & ~$past(n_clr) & ~n_stat) == '0) &&
        (($past(e_stat) & ~$past(e_clr) & ~e_stat) == '0))
        else $error("status bit dropped without clear");

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(n_clr) & ~$past(n_set) & n_stat) == '0) &&
        (($past(e_clr) & ~$past(e_set) & e_stat) == '0))
        else $error("cleared status bit still set");

    p_unmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(n_en) & n_mask) == '0) && (($past(e_en) & e_mask) == '0))
        else $error("unmask write left mask bit set");

    p_maskset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(n_dis) & ~n_mask) == '0) && (($past(e_dis) & ~e_mask) == '0))
        else $error("mask-set write left mask bit clear");

    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(n_en) | $past(n_dis) | $past(e_en) | $past(e_dis)) == '0)
        |-> ($stable(n_mask) && $stable(e_mask)))
        else $error("mask changed without unmask or mask-set write");
endmodule

bind irq_agg irq_agg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq),
    .n_stat(n_stat), .n_mask(n_mask), .e_stat(e_stat), .e_mask(e_mask),
    .n_set(n_set), .e_set(e_set), .n_clr(n_clr), .e_clr(e_clr),
    .n_en(n_en), .e_en(e_en), .n_dis(n_dis), .e_dis(e_dis)
);

// File: tb/irq_agg_tb.sv
module irq_agg_tb;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NCH-1:0] ch_done = '0, ch_data_err = '0, ch_fetch_err = '0;
    logic [NCH-1:0] ch_preamble_err = '0, ch_crc_err = '0, ch_redone_err = '0;
    logic        vsync = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit started = 0;
    bit finished = 0;

    // behavioural reference state
    logic [31:0] m_ns, m_nm, m_es, m_em;
    logic        m_irq;

    always #5 clk = ~clk;

    irq_agg #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
        .rdata(rdata), .ch_done(ch_done), .ch_data_err(ch_data_err),
        .vsync(vsync), .ch_fetch_err(ch_fetch_err),
        .ch_preamble_err(ch_preamble_err), .ch_crc_err(ch_crc_err),
        .ch_redone_err(ch_redone_err), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // reference model update on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ns = 0; m_es = 0; m_nm = 32'h07FFFFFF; m_em = 32'hFFFFFFFF;
            m_irq = 0;
        end else begin
            logic [31:0] ns_ev, es_ev;
            ns_ev = 0; es_ev = 0;
            for (int c = 0; c < NCH; c++) begin
                if (ch_done[c])         ns_ev[c] = 1;
                if (ch_data_err[c])     ns_ev[12 + c] = 1;
                if (ch_fetch_err[c])    es_ev[1 + c] = 1;
                if (ch_preamble_err[c]) es_ev[7 + c] = 1;
                if (ch_crc_err[c])      es_ev[13 + c] = 1;
                if (ch_redone_err[c])   es_ev[25 + c] = 1;
            end
            if (vsync) ns_ev[27] = 1;
            m_irq = ((m_ns & ~m_nm) != 0) || ((m_es & ~m_em) != 0);
            if (we && addr == 0) m_ns = m_ns & ~wdata;
            if (we && addr == 4) m_es = m_es & ~wdata;
            if (we && addr == 2) m_nm = m_nm & ~wdata;
            if (we && addr == 3) m_nm = m_nm | wdata;
            if (we && addr == 6) m_em = m_em & ~wdata;
            if (we && addr == 7) m_em = m_em | wdata;
            m_ns = m_ns | ns_ev;
            m_es = m_es | es_ev;
        end
    end

    // per-cycle comparison of the interrupt line
    always @(negedge clk) begin
        if (started && !finished)
            chk(irq === m_irq, "R7 per-cycle irq", {31'd0, irq}, {31'd0, m_irq});
    end

    task automatic idle_inputs();
        we = 0; wdata = 0;
        ch_done = 0; ch_data_err = 0; vsync = 0;
        ch_fetch_err = 0; ch_preamble_err = 0; ch_crc_err = 0; ch_redone_err = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); idle_inputs(); we = 1; addr = a; wdata = d;
        @(negedge clk); idle_inputs();
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); idle_inputs(); addr = a; #1;
        chk(rdata === exp, req, rdata, exp);
    endtask

    task automatic irq_is(input bit exp, input string req);
        repeat (2) @(negedge clk);
        #1 chk(irq === exp, req, {31'd0, irq}, {31'd0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        started = 1;
        #1 chk(irq === 1'b0, "R1 irq after reset", {31'd0, irq}, 0);
        rd(0, 32'h0, "R1 normal status");
        rd(1, 32'h07FFFFFF, "R1 normal mask");
        rd(4, 32'h0, "R1 error status");
        rd(5, 32'hFFFFFFFF, "R1 error mask");

        // R8 completion of channel 2, masked at reset
        @(negedge clk); idle_inputs(); ch_done[2] = 1;
        rd(0, 32'h4, "R8 done ch2 at bit 2");
        rd(0, 32'h4, "R11 status sticky");
        irq_is(0, "R7 masked event no irq");

        // R3 unmask bit 2
        wr(2, 32'h4);
        rd(1, 32'h07FFFFFB, "R3 unmask clears mask bit");
        rd(2, 32'h0, "R3 unmask port reads zero");
        irq_is(1, "R7 unmasked status raises irq");

        // R5 direct mask writes ignored
        wr(1, 32'h0);
        rd(1, 32'h07FFFFFB, "R5 normal mask write ignored");
        wr(5, 32'h0);
        rd(5, 32'hFFFFFFFF, "R5 error mask write ignored");

        // R2 write-one-to-clear
        wr(0, 32'h0);
        rd(0, 32'h4, "R2 zero write keeps status");
        wr(0, 32'h4);
        rd(0, 32'h0, "R2 one write clears status");
        irq_is(0, "R7 irq drops after clear");

        // R8 data error ch1 and frame sync
        @(negedge clk); idle_inputs(); ch_data_err[1] = 1; vsync = 1;
        rd(0, 32'h08002000, "R8 data err ch1 bit 13, vsync bit 27");
        wr(0, 32'hFFFFFFFF);

        // R9 error bank layout
        @(negedge clk); idle_inputs();
        ch_fetch_err[0] = 1; ch_preamble_err[5] = 1; ch_crc_err[3] = 1; ch_redone_err[4] = 1;
        rd(4, 32'h20011002, "R9 error bit positions");
        irq_is(0, "R7 error masked no irq");
        wr(6, 32'h2);
        rd(5, 32'hFFFFFFFD, "R3 error unmask");
        irq_is(1, "R7 error bank raises irq");
        wr(7, 32'h2);
        rd(5, 32'hFFFFFFFF, "R4 error mask-set");
        rd(7, 32'h0, "R4 mask-set port reads zero");
        irq_is(0, "R7 irq drops after mask-set");
        wr(4, 32'hFFFFFFFF);
        rd(4, 32'h0, "R2 error status cleared");

        // R6 set beats clear in the same cycle
        @(negedge clk); idle_inputs(); ch_done[0] = 1; we = 1; addr = 0; wdata = 32'h1;
        rd(0, 32'h1, "R6 normal set wins over clear");
        @(negedge clk); idle_inputs(); ch_fetch_err[2] = 1; we = 1; addr = 4; wdata = 32'h8;
        rd(4, 32'h8, "R6 error set wins over clear");
        wr(0, 32'hFFFFFFFF);
        wr(4, 32'hFFFFFFFF);

        // R10 all events at once
        @(negedge clk); idle_inputs();
        ch_done = '1; ch_data_err = '1; vsync = 1;
        ch_fetch_err = '1; ch_preamble_err = '1; ch_crc_err = '1; ch_redone_err = '1;
        rd(0, 32'h0803F03F, "R10 normal implemented bits only");
        rd(4, 32'h7E07FFFE, "R10 error implemented bits only");
        wr(0, 32'h0000003F);
        rd(0, 32'h0803F000, "R2 partial clear");
        wr(2, 32'hFFFFFFFF);
        irq_is(1, "R7 all unmasked");
        wr(3, 32'hFFFFFFFF);
        rd(1, 32'hFFFFFFFF, "R4 normal mask-set all");
        rd(3, 32'h0, "R4 normal mask-set reads zero");
        irq_is(0, "R7 all masked");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule